// File: doc/BRIEF.md
# Debug mode entry controller

This block sits beside a processor core and decides, for every trigger that could stop normal execution, whether the core drops into background debug mode or takes its ordinary fallback. Debug mode can only be armed through the breakpoint pin. The active-low pin is passed through a clock synchronizer and sampled once, on the first clock edge after reset is released. The resulting enable bit holds until the next reset.

Five trigger sources are considered each cycle: a double bus fault, an external breakpoint, a peripheral breakpoint, the reserved background opcode from the decoder, and the software breakpoint opcodes. An external breakpoint is an acknowledge strobe seen while the synchronized pin is low. One source wins on a fixed priority. The next cycle carries a single-cycle action pulse with a 2-bit action code. When the action is an exception, the pulse also carries an 8-bit vector and an acknowledge-cycle request.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: The enable bit `dbg_armed` is loaded on the first clock edge after `rst_n` rises. It becomes 1 when the synchronized pin is low at that edge. With the default two-stage synchronizer, a pin held low for two clock edges before release is enough. A pin low for only one edge leaves it 0. During reset it reads 0.
- R2: Once loaded, `dbg_armed` ignores any later pin activity. It is loaded again after every reset.
- R3: An action is reported one clock after the sampling edge of its source, as a single-cycle pulse on `act_valid`. The codes are 0 = enter debug, 1 = exception, 2 = illegal-instruction trap, 3 = halt. A cycle with no source gives no pulse, and during reset all outputs are 0.
- R4: A double bus fault gives code 0 when enabled and code 3 when disabled.
- R5: An external breakpoint is `bus_ack` high while the synchronized pin is low. It gives code 0 when enabled and code 1 with vector 0x0C when disabled.
- R6: A peripheral breakpoint gives code 0 when enabled and code 1 with vector 0x0C when disabled.
- R7: A valid opcode 0x4AFA gives code 0 when enabled and code 2 when disabled. Without `op_valid` it does nothing.
- R8: Valid opcodes 0x4848 through 0x484F always give code 2, whatever the enable bit. Other opcodes give no action.
- R9: When sources coincide, the winner follows this order: double fault first, then external breakpoint, then peripheral breakpoint, then background opcode, then software breakpoint opcode.
- R10: `act_vec` is 0 unless the action is code 1. `iack_req` is high only together with code 1, so entering debug never requests an acknowledge cycle.
- R11: For the first bus cycle after reset, a breakpoint is tagged only if the synchronized pin is still low when that cycle's `bus_ack` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| bkpt_n | input | 1 | Asynchronous active-low breakpoint pin |
| bus_ack | input | 1 | Bus cycle acknowledge sampling strobe |
| dbl_fault | input | 1 | Double bus fault event |
| per_bkpt | input | 1 | Internal peripheral breakpoint event |
| op_valid | input | 1 | Decoder opcode qualifier |
| opcode | input | 16 | Opcode from the decoder |
| dbg_armed | output | 1 | Debug mode enable bit |
| act_valid | output | 1 | Action pulse |
| act_code | output | 2 | Action code |
| act_vec | output | 8 | Exception vector, valid with code 1 |
| iack_req | output | 1 | Acknowledge bus cycle request |

## Verification
The bench builds the block with its default parameters. These are a two-stage synchronizer, background opcode 0x4AFA, a software breakpoint family of eight opcodes from 0x4848, and breakpoint vector 0x0C. With two stages, the arming edge can be tested at its exact boundary: two low edges arm and one does not. The early-tag window after release is also exactly two cycles wide. The eight-opcode family lets both of its end values be checked against a neighbouring opcode that must produce nothing.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;

  localparam int VEC_W = 8;

  typedef enum logic [1:0] {
    ACT_DEBUG = 2'd0,
    ACT_EXC   = 2'd1,
    ACT_ILL   = 2'd2,
    ACT_HALT  = 2'd3
  } act_e;

  typedef struct packed {
    logic             valid;
    act_e             code;
    logic [VEC_W-1:0] vec;
    logic             iack;
  } act_t;

  // Exact match against the background opcode.
  function automatic logic op_is_bgnd(input logic [15:0] op, input logic [15:0] ref_op);
    return op == ref_op;
  endfunction

  // Match a family of opcodes that differ only in their low LSB_W bits.
  function automatic logic op_is_family(input logic [15:0] op, input logic [15:0] base,
                                        input int lsb_w);
    logic [15:0] mask;
    mask = 16'hFFFF << lsb_w;
    return (op & mask) == (base & mask);
  endfunction

  // Priority resolution of the trigger sources into one action.
  function automatic act_t resolve(input logic en, input logic dbl, input logic ext,
                                   input logic per, input logic bgnd, input logic swbk,
                                   input logic [VEC_W-1:0] bkpt_vec);
    act_t a;
    a = '{valid: 1'b0, code: ACT_DEBUG, vec: '0, iack: 1'b0};
    if (dbl) begin
      a.valid = 1'b1;
      a.code  = en ? ACT_DEBUG : ACT_HALT;
    end else if (ext || per) begin
      a.valid = 1'b1;
      if (en) a.code = ACT_DEBUG;
      else begin
        a.code = ACT_EXC;
        a.vec  = bkpt_vec;
        a.iack = 1'b1;
      end
    end else if (bgnd) begin
      a.valid = 1'b1;
      a.code  = en ? ACT_DEBUG : ACT_ILL;
    end else if (swbk) begin
      a.valid = 1'b1;
      a.code  = ACT_ILL;
    end
    return a;
  endfunction

endpackage

// File: rtl/dbg_pin_sync.sv
module dbg_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d_n,
  output logic q_n
);
  logic [STAGES-1:0] chain;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) chain[0] <= d_n;
      end else begin : g_next
        always_ff @(posedge clk) chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign q_n = chain[STAGES-1];
endmodule

// File: rtl/dbg_enable_latch.sv
module dbg_enable_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_sync_n,
  output logic armed,
  output logic live
);
  logic load_edge;

  // live goes high on the first edge after reset release; that same edge loads the enable.
  assign load_edge = ~live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live  <= 1'b0;
      armed <= 1'b0;
    end else begin
      live <= 1'b1;
      if (load_edge) armed <= ~pin_sync_n;
    end
  end

  // R1: the enable equals the synchronized pin seen at the release edge
  p_arm_sample_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(live) |-> (armed == !$past(pin_sync_n)));

  // R2: no pin activity moves the enable after it is loaded
  p_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(live)) |-> $stable(armed));
endmodule

// File: rtl/dbg_src_arbiter.sv
module dbg_src_arbiter
  import dbg_entry_pkg::*;
#(
  parameter logic [15:0]      BGND_OP   = 16'h4AFA,
  parameter logic [15:0]      SWBK_BASE = 16'h4848,
  parameter int               SWBK_LSB  = 3,
  parameter logic [VEC_W-1:0] BKPT_VEC  = 8'h0C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             live,
  input  logic             en,
  input  logic             dbl_ev,
  input  logic             ext_ev,
  input  logic             per_ev,
  input  logic             op_valid,
  input  logic [15:0]      opcode,
  output logic             act_valid,
  output logic [1:0]       act_code,
  output logic [VEC_W-1:0] act_vec,
  output logic             iack_req
);
  logic bgnd_ev, swbk_ev, any_ev;
  act_t nxt, cur;

  assign bgnd_ev = live && op_valid && op_is_bgnd(opcode, BGND_OP);
  assign swbk_ev = live && op_valid && op_is_family(opcode, SWBK_BASE, SWBK_LSB);
  assign any_ev  = live && (dbl_ev || ext_ev || per_ev || bgnd_ev || swbk_ev);

  always_comb begin
    nxt = resolve(en, live && dbl_ev, live && ext_ev, live && per_ev, bgnd_ev, swbk_ev, BKPT_VEC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '{valid: 1'b0, code: ACT_DEBUG, vec: '0, iack: 1'b0};
    else        cur <= nxt;
  end

  assign act_valid = cur.valid;
  assign act_code  = cur.code;
  assign act_vec   = cur.vec;
  assign iack_req  = cur.iack;

  // R3: no source, no pulse
  p_no_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !any_ev |=> !act_valid);

  // R4: a double fault always wins and maps by enable
  p_dbl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (live && dbl_ev) |=> act_valid && (act_code == ($past(en) ? ACT_DEBUG : ACT_HALT)));

  // R4: halt only when disabled
  p_halt_dis_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && act_code == ACT_HALT) |-> !en);

  // R10: debug entry never asks for an acknowledge cycle
  p_dbg_noack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && act_code == ACT_DEBUG) |-> (en && !iack_req));

  // R10: vector zero outside exceptions
  p_vec_exc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(act_valid && act_code == ACT_EXC) |-> (act_vec == '0 && !iack_req));
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl #(
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] BGND_OP     = 16'h4AFA,
  parameter logic [15:0] SWBK_BASE   = 16'h4848,
  parameter int          SWBK_LSB    = 3,
  parameter logic [7:0]  BKPT_VEC    = 8'h0C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bkpt_n,
  input  logic        bus_ack,
  input  logic        dbl_fault,
  input  logic        per_bkpt,
  input  logic        op_valid,
  input  logic [15:0] opcode,
  output logic        dbg_armed,
  output logic        act_valid,
  output logic [1:0]  act_code,
  output logic [7:0]  act_vec,
  output logic        iack_req
);
  logic pin_sync_n;
  logic live;
  logic ext_ev;

  dbg_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d_n (bkpt_n),
    .q_n (pin_sync_n)
  );

  dbg_enable_latch u_en (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_sync_n (pin_sync_n),
    .armed      (dbg_armed),
    .live       (live)
  );

  // external breakpoint: acknowledge sampled while synchronized pin is low
  assign ext_ev = bus_ack && !pin_sync_n;

  dbg_src_arbiter #(
    .BGND_OP   (BGND_OP),
    .SWBK_BASE (SWBK_BASE),
    .SWBK_LSB  (SWBK_LSB),
    .BKPT_VEC  (BKPT_VEC)
  ) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .live      (live),
    .en        (dbg_armed),
    .dbl_ev    (dbl_fault),
    .ext_ev    (ext_ev),
    .per_ev    (per_bkpt),
    .op_valid  (op_valid),
    .opcode    (opcode),
    .act_valid (act_valid),
    .act_code  (act_code),
    .act_vec   (act_vec),
    .iack_req  (iack_req)
  );

  // R11: an acknowledge with the synchronized pin high, and nothing else, tags nothing
  p_ext_tag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (live && bus_ack && pin_sync_n && !dbl_fault && !per_bkpt && !op_valid) |=> !act_valid);
endmodule

// File: tb/dbg_entry_ctrl_tb_top.sv
module dbg_entry_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, bkpt_n, bus_ack, dbl_fault, per_bkpt, op_valid;
  logic [15:0] opcode;
  logic        dbg_armed, act_valid, iack_req;
  logic [1:0]  act_code;
  logic [7:0]  act_vec;
  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  dbg_entry_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bkpt_n(bkpt_n), .bus_ack(bus_ack),
    .dbl_fault(dbl_fault), .per_bkpt(per_bkpt), .op_valid(op_valid), .opcode(opcode),
    .dbg_armed(dbg_armed), .act_valid(act_valid), .act_code(act_code),
    .act_vec(act_vec), .iack_req(iack_req)
  );

  // {en, dbl, ext, per, opv, opcode[15:0], exp_valid, exp_code[1:0], exp_vec[7:0]}
  localparam int NV = 18;
  localparam logic [31:0] VECS [NV] = '{
    {1'b0,1'b1,1'b0,1'b0,1'b0,16'h0000,1'b1,2'd3,8'h00},  // R4 fault disabled -> halt
    {1'b0,1'b0,1'b1,1'b0,1'b0,16'h0000,1'b1,2'd1,8'h0C},  // R5 ext disabled -> exception
    {1'b0,1'b0,1'b0,1'b1,1'b0,16'h0000,1'b1,2'd1,8'h0C},  // R6 periph disabled
    {1'b0,1'b0,1'b0,1'b0,1'b1,16'h4AFA,1'b1,2'd2,8'h00},  // R7 bgnd disabled -> illegal
    {1'b0,1'b0,1'b0,1'b0,1'b1,16'h4848,1'b1,2'd2,8'h00},  // R8 low end
    {1'b0,1'b0,1'b0,1'b0,1'b1,16'h484F,1'b1,2'd2,8'h00},  // R8 high end
    {1'b0,1'b0,1'b0,1'b0,1'b1,16'h4850,1'b0,2'd0,8'h00},  // R8 neighbour
    {1'b0,1'b0,1'b0,1'b0,1'b0,16'h4AFA,1'b0,2'd0,8'h00},  // R7 not valid
    {1'b0,1'b1,1'b1,1'b0,1'b0,16'h0000,1'b1,2'd3,8'h00},  // R9 fault over ext
    {1'b0,1'b0,1'b1,1'b1,1'b1,16'h4AFA,1'b1,2'd1,8'h0C},  // R9 ext over bgnd
    {1'b1,1'b1,1'b0,1'b0,1'b0,16'h0000,1'b1,2'd0,8'h00},  // R4 enabled
    {1'b1,1'b0,1'b1,1'b0,1'b0,16'h0000,1'b1,2'd0,8'h00},  // R5 enabled
    {1'b1,1'b0,1'b0,1'b1,1'b0,16'h0000,1'b1,2'd0,8'h00},  // R6 enabled
    {1'b1,1'b0,1'b0,1'b0,1'b1,16'h4AFA,1'b1,2'd0,8'h00},  // R7 enabled
    {1'b1,1'b0,1'b0,1'b0,1'b1,16'h484A,1'b1,2'd2,8'h00},  // R8 enabled still illegal
    {1'b1,1'b0,1'b0,1'b1,1'b1,16'h4AFA,1'b1,2'd0,8'h00},  // R9 periph over bgnd
    {1'b1,1'b0,1'b0,1'b1,1'b1,16'h4848,1'b1,2'd0,8'h00},  // R9 periph over swbk
    {1'b1,1'b0,1'b0,1'b0,1'b1,16'h4E71,1'b0,2'd0,8'h00}   // R8 other opcode
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_src();
    bus_ack = 0; dbl_fault = 0; per_bkpt = 0; op_valid = 0; opcode = 16'h0;
  endtask

  // reset with the pin at a level, held for 'low_edges' edges before release
  task automatic do_reset(input logic pin, input int low_edges);
    @(negedge clk);
    rst_n = 0; bkpt_n = 1; clear_src();
    repeat (3) @(negedge clk);
    bkpt_n = pin;
    repeat (low_edges) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    bkpt_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic apply(input logic [31:0] v, input int idx);
    string tag;
    tag = $sformatf("R3/vec%0d", idx);
    if (v[29]) begin
      bkpt_n = 0;
      repeat (2) @(negedge clk);
    end
    dbl_fault = v[30]; bus_ack = v[29]; per_bkpt = v[28]; op_valid = v[27]; opcode = v[26:11];
    @(negedge clk);
    chk({tag, " valid"}, act_valid, v[10]);
    if (v[10]) chk({tag, " code"}, act_code, v[9:8]);
    chk({tag, " R10 vec"}, act_vec, v[7:0]);
    chk({tag, " R10 iack"}, iack_req, v[10] && v[9:8] == 2'd1);
    clear_src(); bkpt_n = 1;
    @(negedge clk);
    chk({tag, " pulse end"}, act_valid, 1'b0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; bkpt_n = 1; clear_src();
    repeat (3) @(negedge clk);
    chk("R3 reset valid", act_valid, 1'b0);
    chk("R1 reset armed", dbg_armed, 1'b0);
    chk("R3 reset vec", act_vec, 8'h0);

    // table walk, disabled phase then enabled phase
    for (int ph = 0; ph < 2; ph++) begin
      do_reset(ph == 1 ? 1'b0 : 1'b1, 3);
      chk("R1 phase armed", dbg_armed, ph[0]);
      for (int i = 0; i < NV; i++)
        if (VECS[i][31] == ph[0]) apply(VECS[i], i);
    end

    // R1 boundary: exactly two low edges arms, one does not
    @(negedge clk); rst_n = 0; bkpt_n = 1;
    repeat (4) @(negedge clk);
    bkpt_n = 0; repeat (2) @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1 two edges", dbg_armed, 1'b1);
    // R2: pin toggling afterwards is ignored
    for (int k = 0; k < 6; k++) begin bkpt_n = k[0]; @(negedge clk); end
    bkpt_n = 1; repeat (3) @(negedge clk);
    chk("R2 hold after toggles", dbg_armed, 1'b1);

    @(negedge clk); rst_n = 0; bkpt_n = 1;
    repeat (4) @(negedge clk);
    bkpt_n = 0; @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1 one edge", dbg_armed, 1'b0);
    bkpt_n = 0; repeat (4) @(negedge clk);
    chk("R2 no rearm", dbg_armed, 1'b0);
    bkpt_n = 1; repeat (3) @(negedge clk);

    // R11: first cycle after release is tagged only while the synchronized pin is low
    @(negedge clk); rst_n = 0; bkpt_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    bkpt_n = 1; bus_ack = 1;
    @(negedge clk);
    chk("R11 early ack tagged", act_valid, 1'b1);
    chk("R11 early ack code", act_code, 2'd0);
    bus_ack = 0;
    @(negedge clk);
    bus_ack = 1;
    @(negedge clk);
    chk("R11 late ack untagged", act_valid, 1'b0);
    bus_ack = 0;
    chk("R2 armed after release", dbg_armed, 1'b1);
    repeat (2) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule